// File: doc/BRIEF.md
# TDM Serial Link Frame Receiver

This block sits on the controller side of a serial audio/modem link and receives the data line that one codec drives back. The link carries fixed 256-bit frames: a 16-bit tag field followed by twelve 20-bit slots, all sent MSB first. A frame begins when the frame-sync line rises. The receiver deserializes every field. It decodes the codec-ready flag and the per-slot valid flags from the tag. It then hands out sample words, register read responses, slot-request bits and general-purpose pin status.

The clock input is the serial bit clock. Sync and data are captured on its rising edge, one cycle after the far end drives them. Register reads are tracked one at a time. The host pulses a read-issue input with the register index it has just sent. The receiver then waits for a status slot that echoes that index. It reports the data with a strobe, or it raises a timeout pulse if no echo arrives within a parameterised number of frames.

Top module: `tdm_frame_rx`

## Requirements
- R1: A frame starts in the cycle where `sync_i` is sampled high after being sampled low, and the `sdin_i` bit sampled in that cycle is frame bit 0. Frame bit k for k in 0..15 is tag bit 15-k. Slot s (1..12) occupies frame bits 16+20(s-1) to 35+20(s-1), MSB first. Sync held high does not restart the frame, and a new rising edge restarts it even partway through a frame.
- R2: `codec_ready_o` takes tag bit 15 and is visible in the cycle after the last tag bit is sampled.
- R3: `slot_valid_o[i]` takes tag bit 14-i, which is the valid flag of slot i+1, and updates in the same cycle as R2.
- R4: In the cycle after the last bit of slot s (3..11) is sampled, `sample_vld_o` pulses for one cycle, provided the frame's ready flag and the slot's valid flag are both 1. In that cycle `sample_o` carries the slot word and `sample_slot_o` carries s.
- R5: While the current frame's ready flag is 0, no sample, slot-request, GPIO or read-response update takes place.
- R6: Only the top SAMPLE_RES bits of a sample are passed on. The lower 20-SAMPLE_RES bits of `sample_o` are forced to 0.
- R7: When slot 1 is valid and the codec is ready, `slot_req_o` takes slot 1 bits 11:2 after the slot's last bit. Slot 1 bits 18:12 are the echoed register index.
- R8: A pulse on `rd_issue_i` arms a pending read for `rd_index_i`. The read completes when slots 1 and 2 are both valid in a ready frame and the echoed index equals the pending index. After the last bit of slot 2, `rd_strobe_o` pulses for one cycle, `rd_data_o` holds slot 2 bits 19:4, and the read is no longer pending.
- R9: An echoed index that differs from the pending one produces no strobe, and the read stays pending.
- R10: Each frame start while a read is pending ages it by one. The frame start that finds it aged TIMEOUT_FRAMES pulses `rd_timeout_o` one cycle later and drops the read. A new issue re-arms the read with age 0.
- R11: When slot 12 is valid and the codec is ready, `gpio_status_o` takes slot 12 bits 19:4 and `gpio_int_o` takes bit 0 after the slot's last bit.
- R12: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame sync from the controller's sync generator |
| sdin_i | input | 1 | Serial data from the codec |
| rd_issue_i | input | 1 | Pulse: a register read was sent in this frame |
| rd_index_i | input | 7 | Register index of that read |
| codec_ready_o | output | 1 | Codec-ready flag of the current frame |
| slot_valid_o | output | 12 | Valid flags, bit i for slot i+1 |
| sample_o | output | 20 | Last delivered sample word |
| sample_slot_o | output | 4 | Slot number of that sample |
| sample_vld_o | output | 1 | One-cycle sample strobe |
| slot_req_o | output | 10 | Slot-request bits from the status address slot |
| rd_data_o | output | 16 | Register read data |
| rd_strobe_o | output | 1 | One-cycle read-response strobe |
| rd_timeout_o | output | 1 | One-cycle read timeout pulse |
| gpio_status_o | output | 16 | GPIO pin status word |
| gpio_int_o | output | 1 | GPIO interrupt event flag |

## Verification
The bench first sends a frame with every slot valid but the ready flag low. This separates a receiver that gates on readiness from one that trusts the valid flags alone. Directed frames then carry a matching echo and a mismatched echo, and the mismatched case is left idle until the read expires. This separates strobe, hold and timeout behaviour and checks the exact frame count of the timeout. A frame cut short by an early sync edge shows that a restart realigns the fields. Random tags and slot words expose any mis-mapped bit position or slot number, and the low sample bits show whether trimming is applied.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int NUM_SLOTS  = 12;
  localparam int FRAME_BITS = TAG_W + SLOT_W * NUM_SLOTS;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int SID_W      = 4;
  localparam logic [SID_W-1:0] SID_NONE = '1;

  // Which field ends at frame bit position pos: 0 = tag, 1..12 = slot, SID_NONE = none
  function automatic logic [SID_W-1:0] field_end(input logic [CNT_W-1:0] pos);
    int p;
    p = int'(pos);
    if (p == TAG_W - 1) return '0;
    if (p >= TAG_W && ((p - TAG_W) % SLOT_W) == SLOT_W - 1)
      return SID_W'((p - TAG_W) / SLOT_W + 1);
    return SID_NONE;
  endfunction

  // Keep the top res bits of an MSB-justified word
  function automatic logic [SLOT_W-1:0] keep_msbs(input logic [SLOT_W-1:0] w, input int res);
    logic [SLOT_W-1:0] r;
    for (int i = 0; i < SLOT_W; i++) r[i] = (i >= SLOT_W - res) ? w[i] : 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
  import tdm_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              sdin_i,
  output logic              frame_start_o,
  output logic              field_done_o,
  output logic [SID_W-1:0]  field_id_o,
  output logic [SLOT_W-1:0] field_word_o
);
  logic              sync_q;
  logic              active;
  logic [CNT_W-1:0]  pos;
  logic [SLOT_W-1:0] shreg;
  logic [CNT_W-1:0]  cur_pos;

  assign frame_start_o = sync_i & ~sync_q;
  assign cur_pos       = frame_start_o ? '0 : pos;
  assign field_id_o    = field_end(cur_pos);
  assign field_done_o  = (frame_start_o | active) && (field_id_o != SID_NONE);
  assign field_word_o  = {shreg[SLOT_W-2:0], sdin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      active <= 1'b0;
      pos    <= '0;
      shreg  <= '0;
    end else begin
      sync_q <= sync_i;
      shreg  <= field_word_o;
      if (frame_start_o) begin
        active <= 1'b1;
        pos    <= CNT_W'(1);
      end else if (active) begin
        if (pos == CNT_W'(FRAME_BITS - 1)) begin
          active <= 1'b0;
          pos    <= '0;
        end else begin
          pos <= pos + CNT_W'(1);
        end
      end
    end
  end

  assert_frame_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> (active && pos == CNT_W'(1)));
endmodule

// File: rtl/tdm_rx_slots.sv
module tdm_rx_slots
  import tdm_rx_pkg::*;
#(
  parameter int SAMPLE_RES = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 field_done_i,
  input  logic [SID_W-1:0]     field_id_i,
  input  logic [SLOT_W-1:0]    field_word_i,
  output logic                 codec_ready_o,
  output logic [NUM_SLOTS-1:0] slot_valid_o,
  output logic [SLOT_W-1:0]    sample_o,
  output logic [SID_W-1:0]     sample_slot_o,
  output logic                 sample_vld_o,
  output logic [9:0]           slot_req_o,
  output logic [6:0]           stat_idx_o,
  output logic                 stat_evt_o,
  output logic [15:0]          stat_data_o,
  output logic [15:0]          gpio_status_o,
  output logic                 gpio_int_o
);
  localparam logic [SLOT_W-1:0] LOW_MASK = (SLOT_W'(1) << (SLOT_W - SAMPLE_RES)) - SLOT_W'(1);

  logic tag_end, stat_addr_end, data_slot_end, gpio_end, slot_ok;

  assign tag_end       = field_done_i && field_id_i == '0;
  assign slot_ok       = (field_id_i != '0) && (field_id_i <= SID_W'(NUM_SLOTS)) &&
                         codec_ready_o && slot_valid_o[field_id_i - SID_W'(1)];
  assign stat_addr_end = field_done_i && field_id_i == SID_W'(1);
  assign data_slot_end = field_done_i && slot_ok &&
                         field_id_i >= SID_W'(3) && field_id_i <= SID_W'(NUM_SLOTS - 1);
  assign gpio_end      = field_done_i && slot_ok && field_id_i == SID_W'(NUM_SLOTS);
  assign stat_evt_o    = field_done_i && field_id_i == SID_W'(2) && codec_ready_o &&
                         slot_valid_o[0] && slot_valid_o[1];
  assign stat_data_o   = field_word_i[19:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codec_ready_o <= 1'b0;
      slot_valid_o  <= '0;
      sample_o      <= '0;
      sample_slot_o <= '0;
      sample_vld_o  <= 1'b0;
      slot_req_o    <= '0;
      stat_idx_o    <= '0;
      gpio_status_o <= '0;
      gpio_int_o    <= 1'b0;
    end else begin
      sample_vld_o <= 1'b0;
      if (tag_end) begin
        codec_ready_o <= field_word_i[TAG_W-1];
        for (int s = 1; s <= NUM_SLOTS; s++) slot_valid_o[s-1] <= field_word_i[TAG_W-1-s];
      end
      if (stat_addr_end && slot_valid_o[0]) begin
        stat_idx_o <= field_word_i[18:12];
        if (codec_ready_o) slot_req_o <= field_word_i[11:2];
      end
      if (data_slot_end) begin
        sample_o      <= keep_msbs(field_word_i, SAMPLE_RES);
        sample_slot_o <= field_id_i;
        sample_vld_o  <= 1'b1;
      end
      if (gpio_end) begin
        gpio_status_o <= field_word_i[19:4];
        gpio_int_o    <= field_word_i[0];
      end
    end
  end

  assert_sample_needs_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld_o |-> codec_ready_o);
  assert_sample_trimmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld_o |-> ((sample_o & LOW_MASK) == '0));
endmodule

// File: rtl/tdm_rx_readtrk.sv
module tdm_rx_readtrk #(
  parameter int TIMEOUT_FRAMES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_start_i,
  input  logic        rd_issue_i,
  input  logic [6:0]  rd_index_i,
  input  logic        stat_evt_i,
  input  logic [6:0]  stat_idx_i,
  input  logic [15:0] stat_data_i,
  output logic        rd_strobe_o,
  output logic [15:0] rd_data_o,
  output logic        rd_timeout_o
);
  localparam int AGE_W = $clog2(TIMEOUT_FRAMES + 1);

  logic             pending;
  logic [6:0]       pend_idx;
  logic [AGE_W-1:0] age;
  logic             match, expire;

  assign match  = pending && stat_evt_i && (stat_idx_i == pend_idx);
  assign expire = pending && frame_start_i && (age == AGE_W'(TIMEOUT_FRAMES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending      <= 1'b0;
      pend_idx     <= '0;
      age          <= '0;
      rd_strobe_o  <= 1'b0;
      rd_data_o    <= '0;
      rd_timeout_o <= 1'b0;
    end else begin
      rd_strobe_o  <= match;
      rd_timeout_o <= expire;
      if (match) rd_data_o <= stat_data_i;
      if (rd_issue_i) begin
        pending  <= 1'b1;
        pend_idx <= rd_index_i;
        age      <= '0;
      end else if (match || expire) begin
        pending <= 1'b0;
      end else if (frame_start_i && pending) begin
        age <= age + AGE_W'(1);
      end
    end
  end

  assert_strobe_had_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe_o |-> $past(pending));
  assert_timeout_drops_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_timeout_o |-> (!pending || $past(rd_issue_i)));
  assert_age_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (age <= AGE_W'(TIMEOUT_FRAMES)));
endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx
  import tdm_rx_pkg::*;
#(
  parameter int SAMPLE_RES     = 18,
  parameter int TIMEOUT_FRAMES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_i,
  input  logic        sdin_i,
  input  logic        rd_issue_i,
  input  logic [6:0]  rd_index_i,
  output logic        codec_ready_o,
  output logic [11:0] slot_valid_o,
  output logic [19:0] sample_o,
  output logic [3:0]  sample_slot_o,
  output logic        sample_vld_o,
  output logic [9:0]  slot_req_o,
  output logic [15:0] rd_data_o,
  output logic        rd_strobe_o,
  output logic        rd_timeout_o,
  output logic [15:0] gpio_status_o,
  output logic        gpio_int_o
);
  logic              frame_start, field_done, stat_evt;
  logic [SID_W-1:0]  field_id;
  logic [SLOT_W-1:0] field_word;
  logic [6:0]        stat_idx;
  logic [15:0]       stat_data;

  tdm_rx_deser u_deser (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .sdin_i(sdin_i),
    .frame_start_o(frame_start), .field_done_o(field_done),
    .field_id_o(field_id), .field_word_o(field_word)
  );

  tdm_rx_slots #(.SAMPLE_RES(SAMPLE_RES)) u_slots (
    .clk(clk), .rst_n(rst_n), .field_done_i(field_done), .field_id_i(field_id),
    .field_word_i(field_word), .codec_ready_o(codec_ready_o), .slot_valid_o(slot_valid_o),
    .sample_o(sample_o), .sample_slot_o(sample_slot_o), .sample_vld_o(sample_vld_o),
    .slot_req_o(slot_req_o), .stat_idx_o(stat_idx), .stat_evt_o(stat_evt),
    .stat_data_o(stat_data), .gpio_status_o(gpio_status_o), .gpio_int_o(gpio_int_o)
  );

  tdm_rx_readtrk #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) u_rdtrk (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .rd_issue_i(rd_issue_i),
    .rd_index_i(rd_index_i), .stat_evt_i(stat_evt), .stat_idx_i(stat_idx),
    .stat_data_i(stat_data), .rd_strobe_o(rd_strobe_o), .rd_data_o(rd_data_o),
    .rd_timeout_o(rd_timeout_o)
  );
endmodule

// File: tb/tdm_frame_rx_tb.sv
module tdm_frame_rx_tb;
  localparam int RES = 18;
  localparam int TO  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0, sdin_i = 1'b0, rd_issue_i = 1'b0;
  logic [6:0] rd_index_i = '0;
  logic        codec_ready_o, sample_vld_o, rd_strobe_o, rd_timeout_o, gpio_int_o;
  logic [11:0] slot_valid_o;
  logic [19:0] sample_o;
  logic [3:0]  sample_slot_o;
  logic [9:0]  slot_req_o;
  logic [15:0] rd_data_o, gpio_status_o;

  always #5 clk = ~clk;

  tdm_frame_rx #(.SAMPLE_RES(RES), .TIMEOUT_FRAMES(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .sdin_i(sdin_i), .rd_issue_i(rd_issue_i),
    .rd_index_i(rd_index_i), .codec_ready_o(codec_ready_o), .slot_valid_o(slot_valid_o),
    .sample_o(sample_o), .sample_slot_o(sample_slot_o), .sample_vld_o(sample_vld_o),
    .slot_req_o(slot_req_o), .rd_data_o(rd_data_o), .rd_strobe_o(rd_strobe_o),
    .rd_timeout_o(rd_timeout_o), .gpio_status_o(gpio_status_o), .gpio_int_o(gpio_int_o)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  bit compare_on = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic fb [0:255];
  int   m_pos = -1;
  bit   m_psync = 0, m_ready = 0;
  bit   m_valid [1:12];
  logic [19:0] m_sample = 0; int m_sslot = 0; bit m_svld = 0;
  logic [9:0]  m_sreq = 0;
  logic [6:0]  m_hidx = 0, m_pidx = 0;
  bit   m_pend = 0; int m_age = 0;
  logic [15:0] m_rdata = 0; bit m_rs = 0, m_to = 0;
  logic [15:0] m_gpio = 0; bit m_gint = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = -1; m_psync = 0; m_ready = 0; m_sample = 0; m_sslot = 0; m_svld = 0;
      m_sreq = 0; m_hidx = 0; m_pidx = 0; m_pend = 0; m_age = 0; m_rdata = 0;
      m_rs = 0; m_to = 0; m_gpio = 0; m_gint = 0;
      for (int s = 1; s <= 12; s++) m_valid[s] = 0;
    end else begin
      bit start;
      m_svld = 0; m_rs = 0; m_to = 0;
      start = sync_i && !m_psync;
      if (start && m_pend) begin
        if (m_age == TO) begin m_to = 1; m_pend = 0; end
        else m_age++;
      end
      if (start) m_pos = 0;
      else if (m_pos >= 0 && m_pos < 255) m_pos++;
      else m_pos = -1;
      if (m_pos >= 0) begin
        fb[m_pos] = sdin_i;
        if (m_pos == 15) begin
          m_ready = fb[0];
          for (int s = 1; s <= 12; s++) m_valid[s] = fb[s];
        end
        if (m_pos >= 16 && (m_pos - 16) % 20 == 19) begin
          int s; logic [19:0] w;
          s = (m_pos - 16) / 20 + 1;
          for (int k = 0; k < 20; k++) w[19-k] = fb[16 + 20*(s-1) + k];
          if (s == 1 && m_valid[1]) begin
            m_hidx = w[18:12];
            if (m_ready) m_sreq = w[11:2];
          end
          if (s == 2 && m_ready && m_valid[1] && m_valid[2] && m_pend && m_hidx == m_pidx) begin
            m_rs = 1; m_rdata = w[19:4]; m_pend = 0;
          end
          if (s >= 3 && s <= 11 && m_ready && m_valid[s]) begin
            m_svld = 1; m_sslot = s; m_sample = w & ~((20'd1 << (20 - RES)) - 20'd1);
          end
          if (s == 12 && m_ready && m_valid[12]) begin
            m_gpio = w[19:4]; m_gint = w[0];
          end
        end
      end
      if (rd_issue_i) begin m_pend = 1; m_pidx = rd_index_i; m_age = 0; end
      m_psync = sync_i;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (compare_on && !done) begin
      logic [11:0] v;
      for (int i = 0; i < 12; i++) v[i] = m_valid[i+1];
      check("R2 codec_ready", codec_ready_o, m_ready);
      check("R1/R3 slot_valid", slot_valid_o, v);
      check("R4/R5 sample_vld", sample_vld_o, m_svld);
      check("R4/R6 sample", sample_o, m_sample);
      check("R4 sample_slot", sample_slot_o, m_sslot);
      check("R7 slot_req", slot_req_o, m_sreq);
      check("R8/R9 rd_strobe", rd_strobe_o, m_rs);
      check("R8 rd_data", rd_data_o, m_rdata);
      check("R10 rd_timeout", rd_timeout_o, m_to);
      check("R11 gpio_status", gpio_status_o, m_gpio);
      check("R11 gpio_int", gpio_int_o, m_gint);
    end
  end

  // ---------------- stimulus ----------------
  logic [19:0] sw [1:12];

  function automatic logic [15:0] mk_tag(input bit rdy, input logic [11:0] v);
    logic [15:0] t;
    t = '0; t[15] = rdy;
    for (int i = 0; i < 12; i++) t[14-i] = v[i];
    return t;
  endfunction

  task automatic rand_slots();
    for (int s = 1; s <= 12; s++) sw[s] = 20'($urandom);
  endtask

  task automatic send_frame(input logic [15:0] tag, input int nbits, input int issue_at,
                            input logic [6:0] issue_idx);
    for (int b = 0; b < nbits; b++) begin
      @(negedge clk);
      sync_i     = (b < 16);
      rd_issue_i = (b == issue_at);
      rd_index_i = issue_idx;
      if (b < 16) sdin_i = tag[15-b];
      else sdin_i = sw[(b-16)/20 + 1][19 - (b-16)%20];
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 reset ready", codec_ready_o, 0);
    check("R12 reset valid", slot_valid_o, 0);
    check("R12 reset strobes", {sample_vld_o, rd_strobe_o, rd_timeout_o}, 0);
    check("R12 reset words", {sample_o, slot_req_o, rd_data_o, gpio_status_o, gpio_int_o}, 0);
    rst_n = 1'b1;
    compare_on = 1;

    // R5: all slots flagged valid but codec not ready
    rand_slots();
    send_frame(mk_tag(0, 12'hFFF), 256, -1, 0);
    // R4 R6 R11: ready, a few data slots plus GPIO slot
    rand_slots(); sw[12] = {16'hA5C3, 3'b000, 1'b1};
    send_frame(mk_tag(1, 12'b1000_0100_1100), 256, -1, 0);
    // R8: issue read, then matching echo next frame
    rand_slots();
    send_frame(mk_tag(1, 12'h000), 256, 200, 7'h26);
    rand_slots(); sw[1] = {1'b0, 7'h26, 10'h2A5, 2'b00}; sw[2] = {16'hBEEF, 4'h0};
    send_frame(mk_tag(1, 12'b0000_0000_0011), 256, -1, 0);
    // R9: mismatched echo, then R10 timeout over idle frames
    rand_slots(); sw[1] = {1'b0, 7'h02, 10'h155, 2'b00};
    send_frame(mk_tag(1, 12'b0000_0000_0011), 256, 50, 7'h1C);
    for (int f = 0; f < TO + 1; f++) begin
      rand_slots();
      send_frame(mk_tag(1, 12'b1111_1111_1100), 256, -1, 0);
    end
    // R1: frame cut short by an early sync edge, then random frames
    rand_slots();
    send_frame(mk_tag(1, 12'hFFF), 100, -1, 0);
    for (int f = 0; f < 8; f++) begin
      rand_slots();
      send_frame(mk_tag(1, 12'($urandom)), 256, (f % 3 == 0) ? 120 : -1, 7'($urandom));
    end
    @(negedge clk); sync_i = 0; sdin_i = 0; rd_issue_i = 0;
    repeat (20) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule